// File: doc/BRIEF.md
# Multiply-Accumulate Datapath

This block is the arithmetic heart of a 16-bit signal-processing core. Each clock cycle it can take two 16-bit operands, form their full product in a parallel multiplier and fold that product into one of two 40-bit accumulators. The multiply, the 40-bit add or subtract and the accumulator write all happen in that one cycle, so a multiply-accumulate can be issued back to back without stalls. The eight bits above the 32-bit product act as guard bits, so long sums can grow without wrapping.

An instruction decoder outside this block presents an operation code, a destination select and two format bits on every cycle. One format bit chooses between signed and unsigned operands. The other chooses between integer and fractional format. The block also accepts a 32-bit register value that the combined multiply-add operation adds into the product path. The accumulators can also be added, subtracted or copied into one another, and they can be cleared. Each accumulator has its own sticky overflow flag.

Top module: `mac_datapath`

## Requirements
- R1: While rst_n is low, and after it rises, both accumulators, the product register and both overflow flags read zero.
- R2: Operation code 1 (multiply) loads the selected accumulator with the product and also loads the product register with it. acc_sel 0 selects accumulator 0 and acc_sel 1 selects accumulator 1. The result is visible after the clock edge on which the operation is presented, and the accumulator that is not selected keeps its value. With is_signed=1 the product is signed and is sign-extended to 40 bits.
- R3: With is_signed=0 both operands are unsigned and the product is zero-extended to 40 bits.
- R4: With is_signed=1 and is_frac=1 the product is doubled before it is used. For example, 0x8000 times 0x8000 gives 0x0080000000. With is_frac=1 and is_signed=0 the product is not shifted.
- R5: Operation code 2 adds the product to the selected accumulator and operation code 3 subtracts it. Either can be issued on every cycle, and each result is the start value for the next one.
- R6: Operation code 7 adds the product plus the addend to the selected accumulator. The addend is sign-extended when is_signed=1 and zero-extended when is_signed=0. The product register captures the product plus the addend. Non-multiply operations leave the product register unchanged.
- R7: Operation codes 4, 5 and 6 set the selected accumulator to itself plus the other accumulator, to itself minus the other accumulator, and to a copy of the other accumulator.
- R8: An accumulator's overflow flag is set when an add or subtract into that accumulator leaves the signed 40-bit range, and the stored value then wraps. The flag stays set until that accumulator is cleared.
- R9: clr_mask bit i clears accumulator i and its overflow flag. It wins over any operation aimed at that accumulator in the same cycle. Operation code 8 clears the selected accumulator and its flag.
- R10: When op_valid is 0, or for operation code 0, no accumulator, flag or product register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| acc_sel | input | 1 | Destination accumulator |
| opnd_a | input | 16 | Multiplier operand |
| opnd_b | input | 16 | Multiplicand operand |
| is_signed | input | 1 | 1 = signed operands |
| is_frac | input | 1 | 1 = fractional format |
| addend | input | 32 | Register value for the combined multiply-add |
| clr_mask | input | 2 | Per-accumulator clear, highest priority |
| acc_o | output | 2x40 | Accumulator contents |
| ovf_o | output | 2 | Sticky overflow flags |
| prod_o | output | 40 | Product register |

## Verification
The assertions check on every cycle that a clear wins over a same-cycle operation, that an overflow flag stays set until a clear, and that idle cycles change nothing. They also check that the accumulator that is not selected holds its value, that a move copies the other accumulator, and that non-multiply operations keep the product register. Only the bench scenarios can show that the arithmetic values are right. This covers signed and unsigned products, the fractional doubling including the largest negative times itself, the extension of the addend, chains of accumulate and subtract, and the exact cycle on which a long chain of sums first wraps.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_MPY  = 4'd1,
      OP_MAC  = 4'd2,
      OP_MSU  = 4'd3,
      OP_ADD  = 4'd4,
      OP_SUB  = 4'd5,
      OP_MOV  = 4'd6,
      OP_MACA = 4'd7,
      OP_CLR  = 4'd8
   } mac_op_e;

   function automatic logic is_mult_op(input mac_op_e op);
      return (op == OP_MPY) || (op == OP_MAC) || (op == OP_MSU) || (op == OP_MACA);
   endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int OP_W    = 16,
   parameter int ACC_W   = 40,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic [OP_W-1:0]  a_i,
   input  logic [OP_W-1:0]  b_i,
   input  logic             sg_i,
   input  logic             fr_i,
   output logic [ACC_W-1:0] p_o
);
   // One extra bit per operand lets one signed multiplier serve both formats.
   localparam int PW = 2*OP_W + 2;

   logic signed [OP_W:0]  ax;
   logic signed [OP_W:0]  bx;
   logic signed [PW-1:0]  full;
   logic [ACC_W-1:0]      ext;

   assign ax   = $signed({sg_i & a_i[OP_W-1], a_i});
   assign bx   = $signed({sg_i & b_i[OP_W-1], b_i});
   assign full = ax * bx;
   assign ext  = {{(ACC_W-PW){full[PW-1]}}, full};

   generate
      if (FRAC_EN) begin : g_frac
         // Signed fractional product gets one left shift to align the binary point.
         assign p_o = (sg_i && fr_i) ? {ext[ACC_W-2:0], 1'b0} : ext;
      end else begin : g_int
         logic unused_fr;
         assign unused_fr = fr_i;
         assign p_o = ext;
      end
   endgenerate
endmodule

// File: rtl/mac_alu.sv
module mac_alu #(
   parameter int W = 40
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         sub_i,
   output logic [W-1:0] res_o,
   output logic         ovf_o
);
   logic [W:0] xs;
   logic [W:0] ys;
   logic [W:0] sum;

   assign xs    = {x_i[W-1], x_i};
   assign ys    = {y_i[W-1], y_i};
   assign sum   = sub_i ? (xs - ys) : (xs + ys);
   assign res_o = sum[W-1:0];
   assign ovf_o = sum[W] ^ sum[W-1];
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
   parameter int NUM_ACC = 2,
   parameter int ACC_W   = 40,
   localparam int SEL_W  = $clog2(NUM_ACC)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en_i,
   input  logic [SEL_W-1:0]                wr_sel_i,
   input  logic [ACC_W-1:0]                wr_data_i,
   input  logic                            wr_ovf_i,
   input  logic [NUM_ACC-1:0]              clr_i,
   output logic [NUM_ACC-1:0][ACC_W-1:0]   acc_o,
   output logic [NUM_ACC-1:0]              ovf_o
);
   generate
      for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
         always_ff @(posedge clk) begin
            if (!rst_n || clr_i[i]) begin
               acc_o[i] <= '0;
               ovf_o[i] <= 1'b0;
            end else if (wr_en_i && (wr_sel_i == SEL_W'(i))) begin
               acc_o[i] <= wr_data_i;
               ovf_o[i] <= ovf_o[i] | wr_ovf_i;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
   parameter int OP_W    = 16,
   parameter int ACC_W   = 40,
   parameter int ADD_W   = 32,
   parameter int NUM_ACC = 2,
   parameter bit FRAC_EN = 1'b1,
   localparam int SEL_W  = $clog2(NUM_ACC)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           op_valid,
   input  logic [3:0]                     op_code,
   input  logic [SEL_W-1:0]               acc_sel,
   input  logic [OP_W-1:0]                opnd_a,
   input  logic [OP_W-1:0]                opnd_b,
   input  logic                           is_signed,
   input  logic                           is_frac,
   input  logic [ADD_W-1:0]               addend,
   input  logic [NUM_ACC-1:0]             clr_mask,
   output logic [NUM_ACC-1:0][ACC_W-1:0]  acc_o,
   output logic [NUM_ACC-1:0]             ovf_o,
   output logic [ACC_W-1:0]               prod_o
);
   import mac_pkg::*;

   localparam int PROD_W = 2*OP_W + 2;

   // Elaboration-time parameter checks
   if (ACC_W <= PROD_W) begin : g_bad_acc_w
      $error("ACC_W must exceed 2*OP_W+2 to hold an extended product");
   end
   if (ADD_W >= ACC_W) begin : g_bad_add_w
      $error("ADD_W must be narrower than ACC_W");
   end
   if (NUM_ACC < 2 || (NUM_ACC & (NUM_ACC-1)) != 0) begin : g_bad_num
      $error("NUM_ACC must be a power of two of at least 2");
   end

   mac_op_e                op;
   logic [ACC_W-1:0]       prod_raw;
   logic [ACC_W-1:0]       addend_ext;
   logic [ACC_W-1:0]       prod_path;
   logic [ACC_W-1:0]       acc_self;
   logic [ACC_W-1:0]       acc_other;
   logic [ACC_W-1:0]       alu_y;
   logic                   alu_sub;
   logic [ACC_W-1:0]       alu_res;
   logic                   alu_ovf;
   logic                   wr_en;
   logic [ACC_W-1:0]       wr_data;
   logic                   wr_ovf;
   logic [NUM_ACC-1:0]     clr_eff;
   logic [ACC_W-1:0]       prod_q;

   assign op = mac_op_e'(op_code);

   mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W), .FRAC_EN(FRAC_EN)) u_mult (
      .a_i  (opnd_a),
      .b_i  (opnd_b),
      .sg_i (is_signed),
      .fr_i (is_frac),
      .p_o  (prod_raw)
   );

   assign addend_ext = {{(ACC_W-ADD_W){is_signed & addend[ADD_W-1]}}, addend};
   assign prod_path  = (op == OP_MACA) ? (prod_raw + addend_ext) : prod_raw;

   assign acc_self  = acc_o[acc_sel];
   assign acc_other = acc_o[acc_sel ^ SEL_W'(1)];

   always_comb begin
      alu_y   = prod_path;
      alu_sub = 1'b0;
      wr_en   = 1'b0;
      wr_data = alu_res;
      wr_ovf  = 1'b0;
      if (op_valid) begin
         unique case (op)
            OP_MPY: begin
               wr_en   = 1'b1;
               wr_data = prod_path;
            end
            OP_MAC, OP_MACA: begin
               wr_en  = 1'b1;
               wr_ovf = alu_ovf;
            end
            OP_MSU: begin
               alu_sub = 1'b1;
               wr_en   = 1'b1;
               wr_ovf  = alu_ovf;
            end
            OP_ADD: begin
               alu_y  = acc_other;
               wr_en  = 1'b1;
               wr_ovf = alu_ovf;
            end
            OP_SUB: begin
               alu_y   = acc_other;
               alu_sub = 1'b1;
               wr_en   = 1'b1;
               wr_ovf  = alu_ovf;
            end
            OP_MOV: begin
               wr_en   = 1'b1;
               wr_data = acc_other;
            end
            default: ;
         endcase
      end
   end

   mac_alu #(.W(ACC_W)) u_alu (
      .x_i   (acc_self),
      .y_i   (alu_y),
      .sub_i (alu_sub),
      .res_o (alu_res),
      .ovf_o (alu_ovf)
   );

   // External clears and the clear opcode merge; the bank gives them priority.
   always_comb begin
      clr_eff = clr_mask;
      if (op_valid && op == OP_CLR) clr_eff[acc_sel] = 1'b1;
   end

   mac_acc_bank #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_sel_i  (acc_sel),
      .wr_data_i (wr_data),
      .wr_ovf_i  (wr_ovf),
      .clr_i     (clr_eff),
      .acc_o     (acc_o),
      .ovf_o     (ovf_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) prod_q <= '0;
      else if (op_valid && is_mult_op(op)) prod_q <= prod_path;
   end

   assign prod_o = prod_q;
endmodule

// File: rtl/mac_datapath_chk.sv
module mac_datapath_chk #(
   parameter int OP_W    = 16,
   parameter int ACC_W   = 40,
   parameter int ADD_W   = 32,
   parameter int NUM_ACC = 2,
   localparam int SEL_W  = $clog2(NUM_ACC)
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           op_valid,
   input logic [3:0]                     op_code,
   input logic [SEL_W-1:0]               acc_sel,
   input logic [OP_W-1:0]                opnd_a,
   input logic [OP_W-1:0]                opnd_b,
   input logic                           is_signed,
   input logic                           is_frac,
   input logic [ADD_W-1:0]               addend,
   input logic [NUM_ACC-1:0]             clr_mask,
   input logic [NUM_ACC-1:0][ACC_W-1:0]  acc_o,
   input logic [NUM_ACC-1:0]             ovf_o,
   input logic [ACC_W-1:0]               prod_o
);
   logic unused_in;
   assign unused_in = ^{opnd_a, opnd_b, is_signed, is_frac, addend};

   generate
      for (genvar i = 0; i < NUM_ACC; i++) begin : g_per_acc
         assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            clr_mask[i] |=> (acc_o[i] == '0) && !ovf_o[i]);

         assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_o[i] && !clr_mask[i] && !(op_valid && op_code == 4'd8 && acc_sel == SEL_W'(i)))
            |=> ovf_o[i]);

         assert_other_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && acc_sel != SEL_W'(i) && !clr_mask[i]) |=> $stable(acc_o[i]));
      end
   endgenerate

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && clr_mask == '0) |=> ($stable(acc_o) && $stable(ovf_o) && $stable(prod_o)));

   assert_move_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd6 && clr_mask == '0)
      |=> acc_o[$past(acc_sel)] == $past(acc_o[acc_sel ^ SEL_W'(1)]));

   assert_prod_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == 4'd4 || op_code == 4'd5 || op_code == 4'd6 || op_code == 4'd8))
      |=> $stable(prod_o));
endmodule

bind mac_datapath mac_datapath_chk #(
   .OP_W(OP_W), .ACC_W(ACC_W), .ADD_W(ADD_W), .NUM_ACC(NUM_ACC)
) u_chk (.*);

// File: tb/sim_mac_datapath.sv
module sim_mac_datapath;
   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              op_valid;
   logic [3:0]        op_code;
   logic [0:0]        acc_sel;
   logic [15:0]       opnd_a, opnd_b;
   logic              is_signed, is_frac;
   logic [31:0]       addend;
   logic [1:0]        clr_mask;
   logic [1:0][39:0]  acc_o;
   logic [1:0]        ovf_o;
   logic [39:0]       prod_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_datapath u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .acc_sel(acc_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .is_signed(is_signed), .is_frac(is_frac), .addend(addend),
      .clr_mask(clr_mask), .acc_o(acc_o), .ovf_o(ovf_o), .prod_o(prod_o)
   );

   typedef struct {
      logic [39:0] a0, a1, pr;
      logic [1:0]  ov;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   int          n_checks = 0;
   int          n_fail   = 0;
   logic [39:0] m_acc [2];
   logic [39:0] m_prod;
   logic [1:0]  m_ovf;

   localparam longint MAXV = 64'sd549755813887;
   localparam longint MINV = -64'sd549755813888;

   function automatic longint sx40(input logic [39:0] v);
      return longint'({{24{v[39]}}, v});
   endfunction

   // Driver: drives one operation at the falling edge and predicts its result.
   task automatic issue(input logic [3:0] op, input int sel, input logic [15:0] a,
                        input logic [15:0] b, input bit sg, input bit fr,
                        input logic [31:0] av, input logic [1:0] clr,
                        input bit vld, input string tag);
      longint p, pp, r;
      bit     wr, ov;
      exp_t   e;
      @(negedge clk);
      op_valid = vld; op_code = op; acc_sel = 1'(sel); opnd_a = a; opnd_b = b;
      is_signed = sg; is_frac = fr; addend = av; clr_mask = clr;
      if (sg) p = longint'($signed(a)) * longint'($signed(b));
      else    p = longint'({48'b0, a}) * longint'({48'b0, b});
      if (sg && fr) p = p * 2;
      pp = p;
      if (op == 4'd7) pp = p + (sg ? longint'($signed(av)) : longint'({32'b0, av}));
      wr = 1'b0; ov = 1'b0; r = 0;
      if (vld) begin
         case (op)
            4'd1: begin r = pp; wr = 1'b1; end
            4'd2, 4'd7: begin r = sx40(m_acc[sel]) + pp; wr = 1'b1; ov = 1'b1; end
            4'd3: begin r = sx40(m_acc[sel]) - pp; wr = 1'b1; ov = 1'b1; end
            4'd4: begin r = sx40(m_acc[sel]) + sx40(m_acc[1-sel]); wr = 1'b1; ov = 1'b1; end
            4'd5: begin r = sx40(m_acc[sel]) - sx40(m_acc[1-sel]); wr = 1'b1; ov = 1'b1; end
            4'd6: begin r = sx40(m_acc[1-sel]); wr = 1'b1; end
            default: ;
         endcase
         if (op inside {4'd1, 4'd2, 4'd3, 4'd7}) m_prod = pp[39:0];
      end
      if (wr) begin
         m_acc[sel] = r[39:0];
         if (ov && (r > MAXV || r < MINV)) m_ovf[sel] = 1'b1;
      end
      for (int i = 0; i < 2; i++) begin
         if (clr[i] || (vld && op == 4'd8 && sel == i)) begin
            m_acc[i] = '0;
            m_ovf[i] = 1'b0;
         end
      end
      e.a0 = m_acc[0]; e.a1 = m_acc[1]; e.pr = m_prod; e.ov = m_ovf; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compares after each rising edge that follows a driven operation.
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks++;
         if (acc_o[0] !== e.a0 || acc_o[1] !== e.a1 || prod_o !== e.pr || ovf_o !== e.ov) begin
            n_fail++;
            $display("FAIL %s: acc0=%h acc1=%h prod=%h ovf=%b expected acc0=%h acc1=%h prod=%h ovf=%b",
                     e.tag, acc_o[0], acc_o[1], prod_o, ovf_o, e.a0, e.a1, e.pr, e.ov);
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      m_acc[0] = '0; m_acc[1] = '0; m_prod = '0; m_ovf = '0;
      rst_n = 1'b0; op_valid = 1'b0; op_code = '0; acc_sel = '0; opnd_a = '0; opnd_b = '0;
      is_signed = 1'b0; is_frac = 1'b0; addend = '0; clr_mask = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (acc_o !== '0 || prod_o !== '0 || ovf_o !== '0) begin
         n_fail++;
         $display("FAIL R1 reset: acc=%h prod=%h ovf=%b expected all zero", acc_o, prod_o, ovf_o);
      end

      // R2: signed integer multiply into each accumulator
      issue(4'd1, 0, 16'd3, 16'hFFFC, 1, 0, 0, 2'b00, 1, "R2 mpy signed acc0");
      issue(4'd1, 1, 16'h8000, 16'h7FFF, 1, 0, 0, 2'b00, 1, "R2 mpy signed acc1");
      // R3: unsigned integer
      issue(4'd1, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 2'b00, 1, "R3 mpy unsigned");
      issue(4'd1, 0, 16'hFFFF, 16'd2, 0, 1, 0, 2'b00, 1, "R4 unsigned frac no shift");
      // R4: signed fractional doubling
      issue(4'd1, 0, 16'h4000, 16'h4000, 1, 1, 0, 2'b00, 1, "R4 frac half*half");
      issue(4'd1, 1, 16'h8000, 16'h8000, 1, 1, 0, 2'b00, 1, "R4 frac minus one squared");
      // R5: back-to-back accumulate and subtract
      issue(4'd2, 0, 16'd100, 16'hFF9C, 1, 0, 0, 2'b00, 1, "R5 mac signed");
      issue(4'd2, 0, 16'd7, 16'd9, 1, 0, 0, 2'b00, 1, "R5 mac chained");
      issue(4'd3, 0, 16'h1234, 16'h0F0F, 0, 0, 0, 2'b00, 1, "R5 msu unsigned");
      issue(4'd2, 1, 16'hC000, 16'h2000, 1, 1, 0, 2'b00, 1, "R5 mac frac");
      // R6: multiply with addend
      issue(4'd7, 0, 16'd5, 16'd6, 1, 0, 32'hFFFF_FFF0, 2'b00, 1, "R6 maca signed addend");
      issue(4'd7, 1, 16'd5, 16'd6, 0, 0, 32'hFFFF_FFF0, 2'b00, 1, "R6 maca unsigned addend");
      // R7: accumulator-to-accumulator
      issue(4'd4, 0, 16'd0, 16'd0, 1, 0, 0, 2'b00, 1, "R7 add other");
      issue(4'd5, 1, 16'd0, 16'd0, 1, 0, 0, 2'b00, 1, "R7 sub other");
      issue(4'd6, 0, 16'd0, 16'd0, 1, 0, 0, 2'b00, 1, "R7 move other");
      // R10: idle or invalid cycles change nothing
      issue(4'd2, 0, 16'h7FFF, 16'h7FFF, 1, 0, 32'h1, 2'b00, 0, "R10 valid low");
      issue(4'd0, 1, 16'h7FFF, 16'h7FFF, 1, 0, 32'h1, 2'b00, 1, "R10 nop code");
      // R8: long chain of +1.0 in fractional reaches the signed limit
      issue(4'd1, 0, 16'h8000, 16'h8000, 1, 1, 0, 2'b00, 1, "R8 load +1.0");
      for (int k = 0; k < 258; k++)
         issue(4'd2, 0, 16'h8000, 16'h8000, 1, 1, 0, 2'b00, 1, "R8 accumulate to wrap");
      issue(4'd6, 0, 16'd0, 16'd0, 1, 0, 0, 2'b00, 1, "R8 flag stays on move");
      // R9: clear wins over same-cycle accumulate, opcode clear
      issue(4'd2, 0, 16'd9, 16'd9, 1, 0, 0, 2'b01, 1, "R9 clear beats mac");
      issue(4'd2, 1, 16'd9, 16'd9, 1, 0, 0, 2'b00, 1, "R9 mac after clear");
      issue(4'd8, 1, 16'd0, 16'd0, 1, 0, 0, 2'b00, 1, "R9 clear opcode");
      issue(4'd3, 0, 16'h7FFF, 16'h7FFF, 1, 0, 0, 2'b00, 1, "R5 msu from zero");
      repeat (3) @(posedge clk);
      #2;
      finish_run();
   end
endmodule